// File: doc/BRIEF.md
# Audio Pause Detector

This block decides when an audio stream has been quiet for a programmed length of time. An external comparator drives `levelAbove` high while the audio peak is above a reference level. While `enable` is high, the block samples that bit once per sample tick. The tick comes from a parameterised divider of the system clock, nominally 2341 samples per second.

Each sample feeds a leaky integrator. A quiet sample adds one to it. A loud sample takes off a larger weight, and the value never goes below zero, so short loud bursts only delay detection and do not restart it. When the integrator passes the limit chosen by `ptSel`, the block sets a sticky pause flag and clears the integrator.

The flag is visible on `pauseFlag` whatever the mask is. It reaches `irqOut` only when `irqMask` is high. A status read strobe clears the flag, but only once a hold-off window has passed since the flag was last set.

Top module: `audio_pause_detect`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `pauseFlag` and `irqOut` are 0.
- R2: While `enable` is high, `levelAbove` is sampled once every `TICK_DIV` clock cycles, the first sample falling on the `TICK_DIV`-th rising edge after `enable` rises. A sample with `levelAbove`=0 adds 1 to the integrator. A sample with `levelAbove`=1 subtracts `LOUD_WEIGHT`, which defaults to 8.
- R3: The integrator saturates at zero. A loud sample taken when the value is below `LOUD_WEIGHT` leaves it at 0.
- R4: The limit for `ptSel`=k is floor((k+1)*`PT_STEP_MS`*`SAMPLE_HZ`/1000) samples. With the defaults this gives 23, 46, 70 and 93. On the sample edge where the updated integrator would exceed the limit, `pauseFlag` goes to 1 and the integrator returns to 0.
- R5: Once set, `pauseFlag` stays at 1 until a status read clears it.
- R6: `pauseFlag` sets regardless of `irqMask`. `irqOut` is high exactly when `pauseFlag` and `irqMask` are both high.
- R7: A `statusRead` clears the flag only if it is sampled more than `HOLD_CYCLES` cycles after the edge that last set the flag. Earlier reads leave the flag unchanged. A set in the same cycle as a read wins over the read.
- R8: While `enable` is low, no samples are taken, the flag cannot set, and the integrator, the tick phase and the hold-off count are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Detector running; low clears the integrator, tick phase and hold-off count |
| levelAbove | input | 1 | Comparator bit, 1 while the audio peak is above the reference |
| ptSel | input | PT_SEL_W | Pause-time select, indexes the limit table |
| irqMask | input | 1 | Lets the flag through to the interrupt |
| statusRead | input | 1 | One-cycle status read strobe |
| pauseFlag | output | 1 | Sticky pause-detected flag |
| irqOut | output | 1 | Masked pause interrupt |

## Verification
The integrator and the tick phase are hidden, so a wrong value in either shows only in when `pauseFlag` rises. Any miscount moves that rising edge by whole sample periods, and the shift appears on the first pause after the fault.

The bench therefore pins the exact rising cycle in several cases:
- after a loud run that must saturate at zero,
- after a single loud sample partway through a quiet run,
- after an enable drop,
- for the largest limit.

A wrong hold-off count shows as a flag that clears one cycle early or late, relative to the read strobe.

// File: rtl/apd_pkg.sv
package apd_pkg;

  typedef struct packed {
    logic sampleTick;
    logic clearInteg;
  } apdStrobes_t;

  function automatic int unsigned pauseLimit(int unsigned idx, int unsigned stepMs,
                                             int unsigned rateHz);
    return ((idx + 1) * stepMs * rateHz) / 1000;
  endfunction

endpackage

// File: rtl/apd_datapath.sv
module apd_datapath
  import apd_pkg::*;
#(
  parameter int unsigned PT_SEL_W    = 2,
  parameter int unsigned PT_STEP_MS  = 10,
  parameter int unsigned SAMPLE_HZ   = 2341,
  parameter int unsigned LOUD_WEIGHT = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                levelAbove,
  input  logic [PT_SEL_W-1:0] ptSel,
  input  apdStrobes_t         strobes,
  output logic                pauseHit
);

  localparam int unsigned PT_COUNT  = 1 << PT_SEL_W;
  localparam int unsigned MAX_LIMIT = pauseLimit(PT_COUNT - 1, PT_STEP_MS, SAMPLE_HZ);
  localparam int unsigned INT_W     = $clog2(MAX_LIMIT + LOUD_WEIGHT + 2) + 1;

  logic [INT_W-1:0] limitTab [PT_COUNT];
  logic [INT_W-1:0] integ;
  logic [INT_W-1:0] stepped;
  logic [INT_W-1:0] loudStep;

  for (genvar g = 0; g < PT_COUNT; g++) begin : gLimit
    assign limitTab[g] = INT_W'(pauseLimit(g, PT_STEP_MS, SAMPLE_HZ));
  end

  assign loudStep = INT_W'(LOUD_WEIGHT);

  always_comb begin
    if (levelAbove) begin
      stepped = (integ >= loudStep) ? (integ - loudStep) : '0;
    end else begin
      stepped = integ + INT_W'(1);
    end
  end

  assign pauseHit = strobes.sampleTick && (stepped > limitTab[ptSel]);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearInteg) begin
      integ <= '0;
    end else if (strobes.sampleTick) begin
      integ <= pauseHit ? '0 : stepped;
    end
  end

endmodule

// File: rtl/apd_control.sv
module apd_control
  import apd_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 85434,
  parameter int unsigned HOLD_CYCLES = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        irqMask,
  input  logic        statusRead,
  input  logic        pauseHit,
  output apdStrobes_t strobes,
  output logic        pauseFlag,
  output logic        irqOut
);

  localparam int unsigned TICK_W = $clog2(TICK_DIV + 1);
  localparam int unsigned HOLD_W = $clog2(HOLD_CYCLES + 1);

  logic [TICK_W-1:0] tickCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              tickWrap;
  logic              holdDone;
  logic              flagQ;

  assign tickWrap = (tickCnt == TICK_W'(TICK_DIV - 1));
  assign holdDone = (holdCnt == HOLD_W'(HOLD_CYCLES));

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      tickCnt <= '0;
    end else if (tickWrap) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + TICK_W'(1);
    end
  end

  always_comb begin
    strobes.sampleTick = enable && tickWrap;
    strobes.clearInteg = !enable;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable || pauseHit) begin
      holdCnt <= '0;
    end else if (!holdDone) begin
      holdCnt <= holdCnt + HOLD_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (pauseHit) begin
      flagQ <= 1'b1;
    end else if (statusRead && holdDone) begin
      flagQ <= 1'b0;
    end
  end

  assign pauseFlag = flagQ;
  assign irqOut    = flagQ & irqMask;

endmodule

// File: rtl/audio_pause_detect.sv
module audio_pause_detect
  import apd_pkg::*;
#(
  parameter int unsigned PT_SEL_W    = 2,
  parameter int unsigned PT_STEP_MS  = 10,
  parameter int unsigned SAMPLE_HZ   = 2341,
  parameter int unsigned LOUD_WEIGHT = 8,
  parameter int unsigned TICK_DIV    = 85434,
  parameter int unsigned HOLD_CYCLES = 100000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                levelAbove,
  input  logic [PT_SEL_W-1:0] ptSel,
  input  logic                irqMask,
  input  logic                statusRead,
  output logic                pauseFlag,
  output logic                irqOut
);

  apdStrobes_t strobes;
  logic        pauseHit;

  apd_control #(
    .TICK_DIV   (TICK_DIV),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .irqMask   (irqMask),
    .statusRead(statusRead),
    .pauseHit  (pauseHit),
    .strobes   (strobes),
    .pauseFlag (pauseFlag),
    .irqOut    (irqOut)
  );

  apd_datapath #(
    .PT_SEL_W   (PT_SEL_W),
    .PT_STEP_MS (PT_STEP_MS),
    .SAMPLE_HZ  (SAMPLE_HZ),
    .LOUD_WEIGHT(LOUD_WEIGHT)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .levelAbove(levelAbove),
    .ptSel     (ptSel),
    .strobes   (strobes),
    .pauseHit  (pauseHit)
  );

endmodule

// File: rtl/apd_checker.sv
module apd_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic irqMask,
  input logic statusRead,
  input logic pauseFlag,
  input logic irqOut,
  input logic sampleTick,
  input logic pauseHit
);

  p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> irqMask);

  p_irq_follows_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pauseFlag && irqMask) |-> irqOut);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pauseFlag && !statusRead) |=> pauseFlag);

  p_early_read_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pauseFlag) |=> pauseFlag);

  p_hit_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    pauseHit |-> sampleTick);

  p_hit_sets_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    pauseHit |=> pauseFlag);

  p_idle_no_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !sampleTick);

  p_rise_needs_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pauseFlag) |-> $past(enable));

endmodule

bind audio_pause_detect apd_checker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .irqMask   (irqMask),
  .statusRead(statusRead),
  .pauseFlag (pauseFlag),
  .irqOut    (irqOut),
  .sampleTick(strobes.sampleTick),
  .pauseHit  (pauseHit)
);

// File: tb/audio_pause_detect_test.sv
module audio_pause_detect_test;

  localparam int TDIV = 4;
  localparam int HOLD = 20;
  localparam int STEP = 10;
  localparam int HZ   = 2341;
  localparam int SELW = 2;
  localparam int LW   = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            enable = 1'b0;
  logic            levelAbove = 1'b0;
  logic [SELW-1:0] ptSel = '0;
  logic            irqMask = 1'b0;
  logic            statusRead = 1'b0;
  logic            pauseFlag;
  logic            irqOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  audio_pause_detect #(
    .PT_SEL_W(SELW), .PT_STEP_MS(STEP), .SAMPLE_HZ(HZ), .LOUD_WEIGHT(LW),
    .TICK_DIV(TDIV), .HOLD_CYCLES(HOLD)
  ) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .levelAbove(levelAbove),
    .ptSel(ptSel), .irqMask(irqMask), .statusRead(statusRead),
    .pauseFlag(pauseFlag), .irqOut(irqOut)
  );

  // behavioural reference, advanced on each rising edge
  int mPhase = 0;
  int mLevel = 0;
  int mHold = 0;
  bit mFlag = 1'b0;

  function automatic int limitOf(int sel);
    return ((sel + 1) * STEP * HZ) / 1000;
  endfunction

  always @(posedge clk) begin
    bit hit;
    bit readOk;
    int nxt;
    hit = 1'b0;
    if (!rstN) begin
      mPhase = 0; mLevel = 0; mHold = 0; mFlag = 1'b0;
    end else begin
      readOk = (mHold == HOLD);
      if (!enable) begin
        mPhase = 0; mLevel = 0;
      end else if (mPhase == TDIV - 1) begin
        mPhase = 0;
        if (levelAbove) nxt = (mLevel >= LW) ? mLevel - LW : 0;
        else nxt = mLevel + 1;
        if (nxt > limitOf(int'(ptSel))) begin
          hit = 1'b1; mLevel = 0;
        end else begin
          mLevel = nxt;
        end
      end else begin
        mPhase++;
      end
      if (hit || !enable) mHold = 0;
      else if (mHold < HOLD) mHold++;
      if (hit) mFlag = 1'b1;
      else if (statusRead && readOk) mFlag = 1'b0;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      checks++;
      if (pauseFlag !== mFlag || irqOut !== (mFlag & irqMask)) begin
        errors++;
        $display("FAIL R5/R6 cycle %0d model compare: flag %0b irq %0b expected flag %0b irq %0b",
                 cycles, pauseFlag, irqOut, mFlag, mFlag & irqMask);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearAfterHold();
    levelAbove = 1'b1;
    cyc(HOLD + 2);
    statusRead = 1'b1;
    cyc(1);
    statusRead = 1'b0;
    chk(pauseFlag, 1'b0, "R7 late read clears flag");
  endtask

  task automatic restart();
    enable = 1'b0;
    cyc(2);
    enable = 1'b1;
  endtask

  initial begin
    cyc(3);
    chk(pauseFlag, 1'b0, "R1 flag in reset");
    chk(irqOut, 1'b0, "R1 irq in reset");
    rstN = 1'b1;
    cyc(1);
    chk(pauseFlag, 1'b0, "R1 flag after reset");

    // quiet run, limit 23: set on the 24th sample (edge 96)
    ptSel = 2'd0; irqMask = 1'b1; levelAbove = 1'b0; enable = 1'b1;
    cyc(95);
    chk(pauseFlag, 1'b0, "R4 no flag before limit");
    cyc(1);
    chk(pauseFlag, 1'b1, "R4 flag at limit");
    chk(irqOut, 1'b1, "R6 irq with mask");

    // early reads are ignored
    levelAbove = 1'b1;
    statusRead = 1'b1;
    cyc(1);
    statusRead = 1'b0;
    chk(pauseFlag, 1'b1, "R7 immediate read ignored");
    cyc(HOLD - 2);
    chk(pauseFlag, 1'b1, "R5 flag sticky");
    statusRead = 1'b1;
    cyc(1);
    chk(pauseFlag, 1'b1, "R7 read at hold boundary ignored");
    cyc(1);
    statusRead = 1'b0;
    chk(pauseFlag, 1'b0, "R7 read past hold clears");

    // saturation: 10 loud samples then 24 quiet
    restart();
    levelAbove = 1'b1;
    cyc(40);
    levelAbove = 1'b0;
    cyc(95);
    chk(pauseFlag, 1'b0, "R3 no flag before 24 quiet");
    cyc(1);
    chk(pauseFlag, 1'b1, "R3 floor at zero");
    clearAfterHold();

    // mask low: flag sets, irq stays low
    irqMask = 1'b0;
    restart();
    levelAbove = 1'b0;
    cyc(96);
    chk(pauseFlag, 1'b1, "R6 flag sets while masked");
    chk(irqOut, 1'b0, "R6 irq blocked by mask");
    irqMask = 1'b1;
    cyc(1);
    chk(irqOut, 1'b1, "R6 irq after unmask");
    clearAfterHold();

    // enable drop clears the integrator
    restart();
    levelAbove = 1'b0;
    cyc(80);
    enable = 1'b0;
    cyc(5);
    chk(pauseFlag, 1'b0, "R8 no flag while idle");
    enable = 1'b1;
    cyc(92);
    chk(pauseFlag, 1'b0, "R8 integrator cleared by disable");
    cyc(4);
    chk(pauseFlag, 1'b1, "R8 full count after re-enable");
    clearAfterHold();
    enable = 1'b0;
    levelAbove = 1'b0;
    cyc(300);
    chk(pauseFlag, 1'b0, "R8 no sampling while disabled");

    // loud weight: 20 quiet, 1 loud, 12 quiet -> set at sample 33
    restart();
    levelAbove = 1'b0;
    cyc(80);
    levelAbove = 1'b1;
    cyc(4);
    levelAbove = 1'b0;
    cyc(47);
    chk(pauseFlag, 1'b0, "R2 loud weight delays flag");
    cyc(1);
    chk(pauseFlag, 1'b1, "R2 flag at sample 33");
    clearAfterHold();

    // balanced 8 quiet : 1 loud never pauses
    restart();
    for (int k = 0; k < 10; k++) begin
      levelAbove = 1'b0;
      cyc(32);
      levelAbove = 1'b1;
      cyc(4);
    end
    chk(pauseFlag, 1'b0, "R2 balanced pattern no pause");

    // largest limit 93: set at sample 94, then restart from zero
    ptSel = 2'd3;
    restart();
    levelAbove = 1'b0;
    cyc(375);
    chk(pauseFlag, 1'b0, "R4 sel3 before limit");
    cyc(1);
    chk(pauseFlag, 1'b1, "R4 sel3 at limit");
    cyc(HOLD + 1);
    statusRead = 1'b1;
    cyc(1);
    statusRead = 1'b0;
    chk(pauseFlag, 1'b0, "R7 clear while running");
    cyc(353);
    chk(pauseFlag, 1'b0, "R4 integrator reset after pause");
    cyc(1);
    chk(pauseFlag, 1'b1, "R4 second pause at limit");

    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 200000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule